// File: doc/BRIEF.md
# Hidden Palette Register Unlock Sequencer

This block hides an 8-bit extended register behind the pixel-mask port of a standard palette interface. The host reaches it only by issuing an exact run of back-to-back reads to that port, with no other palette traffic in between. A small saturating counter tracks the run. On the read that completes the run, the hidden byte is returned instead of the usual all-ones value, and the counter restarts. A write issued with the run one read short of completion lands in the hidden register.

All other writes to the pixel-mask port are flagged so the surrounding logic can send them to the ordinary mask register. Any access to the palette index or data ports breaks the run. Read data is combinational with the read strobe. Counter and register updates take effect on the next clock edge.

Top module: `hdac_unlock`

## Requirements
- R1: After reset the hidden register holds 0x00. The counter starts in its locked value 5, so reads issued straight after reset return 0xFF and never select the hidden register.
- R2: After the counter has been cleared, the fifth consecutive pixel-mask read returns the hidden register on `rd_data_o` in the same cycle, with `hidden_sel_o` high.
- R3: Every pixel-mask read that does not complete the unlock run returns 0xFF with `hidden_sel_o` low. The output also reads 0xFF when no read is active.
- R4: A read that returns the hidden register clears the counter to 0. Another five reads then select the hidden register again.
- R5: A pixel-mask write made after exactly four consecutive reads stores `wr_data_i` into the hidden register, with `mask_wr_o` low.
- R6: A pixel-mask write made with any other read count raises `mask_wr_o` in the same cycle and leaves the hidden register unchanged.
- R7: Every pixel-mask write clears the counter to 0, whether or not it stored into the hidden register.
- R8: An access to any other palette port clears the counter to 0. When strobes coincide, this clear takes priority over a write, and a write takes priority over a read.
- R9: The counter counts up to 7 and stays there, so a run of reads started from the locked state never wraps around into the unlock point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mask_rd_i | input | 1 | Host read strobe on the pixel-mask port |
| mask_wr_i | input | 1 | Host write strobe on the pixel-mask port |
| pal_acc_i | input | 1 | Host access to any other palette port |
| wr_data_i | input | 8 | Host write data |
| rd_data_o | output | 8 | Read data for the pixel-mask port |
| hidden_sel_o | output | 1 | The current read is answered from the hidden register |
| mask_wr_o | output | 1 | The current write goes to the normal mask register |

## Verification
A wrong counter value shows up within five reads. Either the unlock read arrives early or late, or a write is misrouted between `mask_wr_o` and the hidden register. A counter that wraps instead of saturating lets a long read run from reset expose the hidden byte. A corrupted hidden register shows up on the next completed unlock run. The bench sweeps every read count from zero to seven before a write, and every byte value through the store-and-recall path.

// File: rtl/hdac_pkg.sv
package hdac_pkg;
  localparam int unsigned HDAC_DATA_W     = 8;
  localparam int unsigned HDAC_UNLOCK_RDS = 4;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_OTHER = 2'd1,
    ACC_WR    = 2'd2,
    ACC_RD    = 2'd3
  } acc_e;

  // other port > mask write > mask read
  function automatic acc_e acc_decode(input logic other, input logic wr, input logic rd);
    if (other)   return ACC_OTHER;
    else if (wr) return ACC_WR;
    else if (rd) return ACC_RD;
    else         return ACC_NONE;
  endfunction
endpackage

// File: rtl/hdac_seq.sv
module hdac_seq
  import hdac_pkg::*;
#(
  parameter int unsigned UNLOCK_RDS = HDAC_UNLOCK_RDS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  input  logic wr_i,
  input  logic other_i,
  output logic armed_o
);
  localparam int unsigned HIT_CNT = UNLOCK_RDS + 1;
  localparam int unsigned CNT_W   = $clog2(HIT_CNT + 2);
  localparam logic [CNT_W-1:0] CNT_ARM = CNT_W'(UNLOCK_RDS);
  localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(HIT_CNT);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  acc_e acc;

  assign acc     = acc_decode(other_i, wr_i, rd_i);
  assign armed_o = (cnt_q == CNT_ARM);

  always_comb begin
    cnt_d = cnt_q;
    unique case (acc)
      ACC_OTHER, ACC_WR: cnt_d = '0;
      ACC_RD: begin
        if (armed_o)             cnt_d = '0;
        else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      end
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= CNT_RST;
    else         cnt_q <= cnt_d;
  end

  p_hit_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && armed_o) |=> (cnt_q == '0));
  p_wr_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cnt_q == '0));
  p_other_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    other_i |=> (cnt_q == '0));
  p_no_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_q > CNT_ARM) && !wr_i && !other_i) |=> (cnt_q > CNT_ARM));
endmodule

// File: rtl/hdac_reg.sv
module hdac_reg
  import hdac_pkg::*;
#(
  parameter int unsigned DATA_W = HDAC_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end

  p_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (q_o == $past(d_i)));
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/hdac_unlock.sv
module hdac_unlock
  import hdac_pkg::*;
#(
  parameter int unsigned DATA_W     = HDAC_DATA_W,
  parameter int unsigned UNLOCK_RDS = HDAC_UNLOCK_RDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mask_rd_i,
  input  logic              mask_wr_i,
  input  logic              pal_acc_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              hidden_sel_o,
  output logic              mask_wr_o
);
  logic              armed;
  logic              hid_we;
  logic [DATA_W-1:0] hid_q;
  acc_e              acc;

  assign acc = acc_decode(pal_acc_i, mask_wr_i, mask_rd_i);

  hdac_seq #(.UNLOCK_RDS(UNLOCK_RDS)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (mask_rd_i),
    .wr_i    (mask_wr_i),
    .other_i (pal_acc_i),
    .armed_o (armed)
  );

  assign hid_we       = (acc == ACC_WR) && armed;
  assign mask_wr_o    = (acc == ACC_WR) && !armed;
  assign hidden_sel_o = (acc == ACC_RD) && armed;
  assign rd_data_o    = hidden_sel_o ? hid_q : '1;

  hdac_reg #(.DATA_W(DATA_W)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (hid_we),
    .d_i    (wr_data_i),
    .q_o    (hid_q)
  );

  p_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mask_wr_o && hidden_sel_o));
endmodule

// File: tb/tb_hdac_unlock.sv
module tb_hdac_unlock;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd = 1'b0, wr = 1'b0, oth = 1'b0;
  logic [7:0] wdat = '0;
  logic [7:0] rdat;
  logic       hsel, mwr;
  int checks = 0, errors = 0;
  int cnt_m = 5;
  logic [7:0] hid_m = 8'h00;

  always #2 clk = ~clk;

  hdac_unlock dut (
    .clk_i(clk), .rst_ni(rst_n), .mask_rd_i(rd), .mask_wr_i(wr),
    .pal_acc_i(oth), .wr_data_i(wdat), .rd_data_o(rdat),
    .hidden_sel_o(hsel), .mask_wr_o(mwr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_rd();
    logic hit;
    string tag;
    @(negedge clk);
    rd = 1'b1;
    hit = (cnt_m == 4);
    tag = hit ? "R2" : (cnt_m >= 5 ? "R9" : "R3");
    #1;
    chk(tag, rdat, hit ? hid_m : 8'hFF);
    chk(tag, hsel, hit);
    @(posedge clk); #0.5;
    rd = 1'b0;
    if (hit) cnt_m = 0;
    else if (cnt_m < 7) cnt_m++;
  endtask

  task automatic do_wr(input logic [7:0] d);
    logic arm;
    @(negedge clk);
    wr = 1'b1; wdat = d;
    arm = (cnt_m == 4);
    #1;
    chk(arm ? "R5" : "R6", mwr, !arm);
    @(posedge clk); #0.5;
    wr = 1'b0;
    if (arm) hid_m = d;
    cnt_m = 0; // R7
  endtask

  task automatic do_oth();
    @(negedge clk);
    oth = 1'b1;
    @(posedge clk); #0.5;
    oth = 1'b0;
    cnt_m = 0; // R8
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle output and locked reads after reset
    #1 chk("R1", rdat, 8'hFF);
    chk("R1", hsel, 0);
    for (int i = 0; i < 10; i++) do_rd(); // R9 saturation from reset
    do_oth();
    for (int i = 0; i < 5; i++) do_rd();  // R1 hidden reads 0x00
    // R4: repeated unlock runs
    for (int i = 0; i < 10; i++) do_rd();
    // R5/R6/R7: sweep read counts before a write
    for (int n = 0; n < 8; n++) begin
      do_oth();
      for (int i = 0; i < n; i++) do_rd();
      do_wr(8'(8'h30 + n));
      for (int i = 0; i < 5; i++) do_rd();
    end
    // R8: other-port access breaks a run at each position
    for (int n = 0; n < 5; n++) begin
      do_oth();
      for (int i = 0; i < n; i++) do_rd();
      do_oth();
      for (int i = 0; i < 5; i++) do_rd();
    end
    // R8 priority: coincident strobes
    do_oth();
    for (int i = 0; i < 4; i++) do_rd();
    @(negedge clk); oth = 1'b1; wr = 1'b1; rd = 1'b1; wdat = 8'hEE;
    #1 chk("R8", mwr, 0);
    chk("R8", hsel, 0);
    @(posedge clk); #0.5; oth = 1'b0; wr = 1'b0; rd = 1'b0;
    cnt_m = 0;
    for (int i = 0; i < 5; i++) do_rd();
    for (int i = 0; i < 4; i++) do_rd();
    @(negedge clk); wr = 1'b1; rd = 1'b1; wdat = 8'h5A;
    #1 chk("R8", mwr, 0);
    chk("R8", hsel, 0);
    @(posedge clk); #0.5; wr = 1'b0; rd = 1'b0;
    hid_m = 8'h5A; cnt_m = 0;
    for (int i = 0; i < 5; i++) do_rd();
    // exhaustive data path
    for (int v = 0; v < 256; v++) begin
      do_oth();
      for (int i = 0; i < 4; i++) do_rd();
      do_wr(8'(v));
      for (int i = 0; i < 5; i++) do_rd();
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule